// File: doc/BRIEF.md
# Cursor Overlay Pixel Mux

This block sits at the tail of a display pipeline. It accepts a stream of 8-bit colour indices, one per clock, each tagged with its screen coordinate. The index is turned into a 24-bit RGB value through an external colour lookup memory. A 64×64 hardware pointer is then laid over the picture. Each pointer pixel is a 2-bit code taken from an external pattern memory. A code of zero lets the underlying picture through. The other three codes replace it with one of three pointer colours.

Both memories sit outside the block and have synchronous read ports. The block drives their read addresses in the same cycle as the incoming pixel and uses the returned data one cycle later.

Two control inputs override the result:
- A blanking control forces every pixel to black.
- A depth code other than the 8-bit indexed mode also forces black, and raises an error flag that travels with the pixel.

Top module: `curs_overlay_mux`

## Requirements
- R1: out_valid, out_x and out_y equal in_valid, in_x and in_y from exactly two clock edges earlier.
- R2: pal_raddr equals in_index in the same cycle. The word returned on pal_rdata after the next edge is the picture colour used for that pixel.
- R3: The pointer origin comes from cfg_cursor_pos: X is bits 23:12 and Y is bits 11:0. A pixel is inside when cx <= x < cx+64 and cy <= y < cy+64. These comparisons do not wrap, so a pointer near coordinate 4095 covers nothing at small coordinates.
- R4: While a pixel is inside the pointer, pat_raddr equals (y-cy)*8 + (x-cx)/8 in the same cycle. The pixel's code is pat_rdata bits [2s+1:2s], where s = (x-cx) mod 8.
- R5: Code 0 outputs the picture colour. Codes 1, 2 and 3 output cur_color_a, cur_color_b and cur_color_c respectively.
- R6: While cfg_cursor_off is 1, no pixel is inside the pointer, and every pixel shows its picture colour.
- R7: While cfg_blank is 1 for a pixel, its out_rgb is 0, whatever the pointer or the picture.
- R8: cfg_depth value 3 selects 8-bit indexed mode. Any other value makes that pixel's out_rgb 0, and out_depth_err is 1 alongside it.
- R9: out_rgb is 0 in every cycle where out_valid is 0.
- R10: During reset, out_valid, out_rgb, out_x, out_y and out_depth_err are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Pixel present this cycle |
| in_x | input | 12 | Pixel column |
| in_y | input | 12 | Pixel row |
| in_index | input | 8 | Colour index of the pixel |
| cfg_cursor_pos | input | 24 | Pointer origin, X in bits 23:12, Y in bits 11:0 |
| cfg_cursor_off | input | 1 | Hide the pointer |
| cfg_blank | input | 1 | Force black output |
| cfg_depth | input | 3 | Pixel depth code, 3 = 8-bit indexed |
| cur_color_a | input | 24 | Colour for pointer code 1 |
| cur_color_b | input | 24 | Colour for pointer code 2 |
| cur_color_c | input | 24 | Colour for pointer code 3 |
| pal_raddr | output | 8 | Colour lookup read address |
| pal_rdata | input | 24 | Colour lookup data, one cycle after the address |
| pat_raddr | output | 9 | Pattern memory word address |
| pat_rdata | input | 16 | Pattern word, one cycle after the address |
| out_valid | output | 1 | Output pixel present |
| out_x | output | 12 | Column of the output pixel |
| out_y | output | 12 | Row of the output pixel |
| out_rgb | output | 24 | Output colour, red in the top byte |
| out_depth_err | output | 1 | Pixel was produced under an unsupported depth |

## Verification
The hardest cases to reach are the pointer edges. The pixel just left of, right of, above and below the 64×64 window must each fall outside, while the bottom-right corner pixel, which uses pattern word 511 and slot 7, must fall inside. A pointer placed at coordinate 4090 also has to stay clear of pixels near zero.

The stimulus pins the pointer at fixed origins and walks pixels onto each edge. Pattern word 0 is set to a value whose slots cycle through codes 0 to 3, so the four codes appear at four neighbouring pixels. The table streams these pixels back to back, which exercises the two-stage pipeline at full rate.

// File: rtl/curmux_pkg.sv
package curmux_pkg;

    typedef enum logic [1:0] {
        CODE_SHOW  = 2'd0,
        CODE_CUR_A = 2'd1,
        CODE_CUR_B = 2'd2,
        CODE_CUR_C = 2'd3
    } cur_code_e;

    localparam logic [2:0] DEPTH_CODE_8BPP = 3'd3;

endpackage

// File: rtl/cursor_hit.sv
module cursor_hit #(
    parameter int COORD_W      = 12,
    parameter int CUR_DIM      = 64,
    parameter int PIX_PER_WORD = 8
) (
    input  logic [COORD_W-1:0]                                     pix_x,
    input  logic [COORD_W-1:0]                                     pix_y,
    input  logic [COORD_W-1:0]                                     cur_x,
    input  logic [COORD_W-1:0]                                     cur_y,
    input  logic                                                   disable_i,
    output logic                                                   hit_o,
    output logic [2*$clog2(CUR_DIM)-$clog2(PIX_PER_WORD)-1:0]      word_o,
    output logic [$clog2(PIX_PER_WORD)-1:0]                        slot_o
);
    localparam int EXT_W   = COORD_W + 1;
    localparam int CUR_LOG = $clog2(CUR_DIM);
    localparam int SLOT_W  = $clog2(PIX_PER_WORD);

    logic [EXT_W-1:0] dx, dy;
    logic             in_x, in_y;

    // widened subtraction: a negative offset sets the top bit, never wraps
    always_comb begin
        dx     = {1'b0, pix_x} - {1'b0, cur_x};
        dy     = {1'b0, pix_y} - {1'b0, cur_y};
        in_x   = (dx < EXT_W'(CUR_DIM));
        in_y   = (dy < EXT_W'(CUR_DIM));
        hit_o  = !disable_i && in_x && in_y;
        word_o = {dy[CUR_LOG-1:0], dx[CUR_LOG-1:SLOT_W]};
        slot_o = dx[SLOT_W-1:0];
    end

    // R3
    always_comb begin
        if (hit_o) begin
            hit_lower_chk: assert (pix_x >= cur_x && pix_y >= cur_y);
        end
    end

endmodule

// File: rtl/color_pick.sv
module color_pick
    import curmux_pkg::*;
#(
    parameter int CHAN_W       = 8,
    parameter int PIX_PER_WORD = 8
) (
    input  logic                              hit_i,
    input  logic [$clog2(PIX_PER_WORD)-1:0]   slot_i,
    input  logic [2*PIX_PER_WORD-1:0]         pat_word_i,
    input  logic [3*CHAN_W-1:0]               pal_rgb_i,
    input  logic [3*CHAN_W-1:0]               cur_a_i,
    input  logic [3*CHAN_W-1:0]               cur_b_i,
    input  logic [3*CHAN_W-1:0]               cur_c_i,
    input  logic                              blank_i,
    input  logic                              depth_bad_i,
    output logic [3*CHAN_W-1:0]               rgb_o
);
    localparam int RGB_W = 3 * CHAN_W;

    cur_code_e  code;
    logic [1:0] code_raw;

    always_comb begin
        code_raw = pat_word_i[{slot_i, 1'b0} +: 2];
        code     = cur_code_e'(code_raw);
        if (blank_i || depth_bad_i) begin
            rgb_o = '0;
        end else if (hit_i) begin
            case (code)
                CODE_CUR_A: rgb_o = cur_a_i;
                CODE_CUR_B: rgb_o = cur_b_i;
                CODE_CUR_C: rgb_o = cur_c_i;
                default:    rgb_o = pal_rgb_i;
            endcase
        end else begin
            rgb_o = pal_rgb_i;
        end
    end

    // R7
    always_comb begin
        if (blank_i) begin
            blank_zero_chk: assert (rgb_o == RGB_W'(0));
        end
    end

endmodule

// File: rtl/curs_overlay_mux.sv
module curs_overlay_mux
    import curmux_pkg::*;
#(
    parameter int COORD_W      = 12,
    parameter int IDX_W        = 8,
    parameter int CHAN_W       = 8,
    parameter int CUR_DIM      = 64,
    parameter int PIX_PER_WORD = 8
) (
    input  logic                                                 clk,
    input  logic                                                 rst_n,
    input  logic                                                 in_valid,
    input  logic [COORD_W-1:0]                                   in_x,
    input  logic [COORD_W-1:0]                                   in_y,
    input  logic [IDX_W-1:0]                                     in_index,
    input  logic [2*COORD_W-1:0]                                 cfg_cursor_pos,
    input  logic                                                 cfg_cursor_off,
    input  logic                                                 cfg_blank,
    input  logic [2:0]                                           cfg_depth,
    input  logic [3*CHAN_W-1:0]                                  cur_color_a,
    input  logic [3*CHAN_W-1:0]                                  cur_color_b,
    input  logic [3*CHAN_W-1:0]                                  cur_color_c,
    output logic [IDX_W-1:0]                                     pal_raddr,
    input  logic [3*CHAN_W-1:0]                                  pal_rdata,
    output logic [2*$clog2(CUR_DIM)-$clog2(PIX_PER_WORD)-1:0]    pat_raddr,
    input  logic [2*PIX_PER_WORD-1:0]                            pat_rdata,
    output logic                                                 out_valid,
    output logic [COORD_W-1:0]                                   out_x,
    output logic [COORD_W-1:0]                                   out_y,
    output logic [3*CHAN_W-1:0]                                  out_rgb,
    output logic                                                 out_depth_err
);
    localparam int RGB_W  = 3 * CHAN_W;
    localparam int SLOT_W = $clog2(PIX_PER_WORD);

    typedef struct packed {
        logic               valid;
        logic [COORD_W-1:0] x;
        logic [COORD_W-1:0] y;
        logic               hit;
        logic [SLOT_W-1:0]  slot;
        logic               blank;
        logic               depth_bad;
    } lookup_t;

    typedef struct packed {
        logic               valid;
        logic [COORD_W-1:0] x;
        logic [COORD_W-1:0] y;
        logic [RGB_W-1:0]   rgb;
        logic               depth_err;
    } emit_t;

    typedef struct packed {
        lookup_t lk;
        emit_t   em;
    } pipe_t;

    pipe_t             st_d, st_q;
    logic              hit_c;
    logic [SLOT_W-1:0] slot_c;
    logic [RGB_W-1:0]  rgb_c;

    cursor_hit #(
        .COORD_W      (COORD_W),
        .CUR_DIM      (CUR_DIM),
        .PIX_PER_WORD (PIX_PER_WORD)
    ) u_hit (
        .pix_x     (in_x),
        .pix_y     (in_y),
        .cur_x     (cfg_cursor_pos[2*COORD_W-1:COORD_W]),
        .cur_y     (cfg_cursor_pos[COORD_W-1:0]),
        .disable_i (cfg_cursor_off),
        .hit_o     (hit_c),
        .word_o    (pat_raddr),
        .slot_o    (slot_c)
    );

    color_pick #(
        .CHAN_W       (CHAN_W),
        .PIX_PER_WORD (PIX_PER_WORD)
    ) u_pick (
        .hit_i       (st_q.lk.hit),
        .slot_i      (st_q.lk.slot),
        .pat_word_i  (pat_rdata),
        .pal_rgb_i   (pal_rdata),
        .cur_a_i     (cur_color_a),
        .cur_b_i     (cur_color_b),
        .cur_c_i     (cur_color_c),
        .blank_i     (st_q.lk.blank),
        .depth_bad_i (st_q.lk.depth_bad),
        .rgb_o       (rgb_c)
    );

    assign pal_raddr = in_index;

    always_comb begin
        st_d = st_q;
        // stage 1: memory reads are in flight, keep the pixel context
        st_d.lk.valid     = in_valid;
        st_d.lk.x         = in_x;
        st_d.lk.y         = in_y;
        st_d.lk.hit       = hit_c;
        st_d.lk.slot      = slot_c;
        st_d.lk.blank     = cfg_blank;
        st_d.lk.depth_bad = (cfg_depth != DEPTH_CODE_8BPP);
        // stage 2: memory data has arrived, choose the colour
        st_d.em.valid     = st_q.lk.valid;
        st_d.em.x         = st_q.lk.x;
        st_d.em.y         = st_q.lk.y;
        st_d.em.rgb       = st_q.lk.valid ? rgb_c : '0;
        st_d.em.depth_err = st_q.lk.depth_bad;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid     = st_q.em.valid;
    assign out_x         = st_q.em.x;
    assign out_y         = st_q.em.y;
    assign out_rgb       = st_q.em.rgb;
    assign out_depth_err = st_q.em.depth_err;

    // R1
    lat_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 2));

    // R1
    lat_xy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_x == $past(in_x, 2) && out_y == $past(in_y, 2)));

    // R7
    blank_black_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(cfg_blank, 2)) |-> (out_rgb == '0));

    // R8
    depth_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_depth_err == ($past(cfg_depth, 2) != DEPTH_CODE_8BPP)));

    // R8
    err_black_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_depth_err |-> (out_rgb == '0));

    // R9
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_rgb == '0));

endmodule

// File: tb/tb_curs_overlay_mux.sv
`timescale 1ns/1ps
module tb_curs_overlay_mux;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [11:0] in_x, in_y;
    logic [7:0]  in_index;
    logic [23:0] cfg_cursor_pos;
    logic        cfg_cursor_off, cfg_blank;
    logic [2:0]  cfg_depth;
    logic [23:0] cur_color_a, cur_color_b, cur_color_c;
    logic [7:0]  pal_raddr;
    logic [23:0] pal_rdata;
    logic [8:0]  pat_raddr;
    logic [15:0] pat_rdata;
    logic        out_valid;
    logic [11:0] out_x, out_y;
    logic [23:0] out_rgb;
    logic        out_depth_err;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    curs_overlay_mux dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
        .in_index(in_index), .cfg_cursor_pos(cfg_cursor_pos),
        .cfg_cursor_off(cfg_cursor_off), .cfg_blank(cfg_blank), .cfg_depth(cfg_depth),
        .cur_color_a(cur_color_a), .cur_color_b(cur_color_b), .cur_color_c(cur_color_c),
        .pal_raddr(pal_raddr), .pal_rdata(pal_rdata), .pat_raddr(pat_raddr),
        .pat_rdata(pat_rdata), .out_valid(out_valid), .out_x(out_x), .out_y(out_y),
        .out_rgb(out_rgb), .out_depth_err(out_depth_err)
    );

    function automatic logic [23:0] pal_fn(input logic [7:0] i);
        return {i, ~i, i ^ 8'h5A};
    endfunction

    function automatic logic [15:0] pat_fn(input logic [8:0] w);
        logic [31:0] t;
        if (w == 9'd0) return 16'hE4E4;
        t = (32'(w) * 32'h2C5B) ^ 32'h1E4B;
        return t[15:0];
    endfunction

    // synchronous-read memory models
    always_ff @(posedge clk) begin
        pal_rdata <= pal_fn(pal_raddr);
        pat_rdata <= pat_fn(pat_raddr);
    end

    function automatic logic [23:0] model(input int x, input int y, input logic [7:0] idx,
                                          input int cx, input int cy, input bit off,
                                          input bit blank, input logic [2:0] d);
        int dx, dy, code;
        logic [15:0] word;
        if (blank || d != 3'd3) return 24'h0;
        dx = x - cx;
        dy = y - cy;
        if (!off && dx >= 0 && dx < 64 && dy >= 0 && dy < 64) begin
            word = pat_fn(9'(dy * 8 + dx / 8));
            code = int'((word >> ((dx % 8) * 2)) & 16'h3);
            if (code == 1) return cur_color_a;
            if (code == 2) return cur_color_b;
            if (code == 3) return cur_color_c;
        end
        return pal_fn(idx);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // fields: req[64:61] x[60:49] y[48:37] idx[36:29] pos[28:5] off[4] blank[3] depth[2:0]
    localparam int N = 17;
    localparam logic [64:0] VEC [0:N-1] = '{
        {4'd5, 12'd100,  12'd200,  8'd5,  12'd100,  12'd200,  1'b0, 1'b0, 3'd3}, // R5 code 0
        {4'd5, 12'd101,  12'd200,  8'd6,  12'd100,  12'd200,  1'b0, 1'b0, 3'd3}, // R5 code 1
        {4'd5, 12'd102,  12'd200,  8'd7,  12'd100,  12'd200,  1'b0, 1'b0, 3'd3}, // R5 code 2
        {4'd5, 12'd103,  12'd200,  8'd8,  12'd100,  12'd200,  1'b0, 1'b0, 3'd3}, // R5 code 3
        {4'd3, 12'd99,   12'd200,  8'd9,  12'd100,  12'd200,  1'b0, 1'b0, 3'd3}, // R3 left
        {4'd3, 12'd164,  12'd200,  8'd10, 12'd100,  12'd200,  1'b0, 1'b0, 3'd3}, // R3 right
        {4'd4, 12'd163,  12'd263,  8'd11, 12'd100,  12'd200,  1'b0, 1'b0, 3'd3}, // R4 last word
        {4'd3, 12'd100,  12'd264,  8'd12, 12'd100,  12'd200,  1'b0, 1'b0, 3'd3}, // R3 below
        {4'd3, 12'd100,  12'd199,  8'd13, 12'd100,  12'd200,  1'b0, 1'b0, 3'd3}, // R3 above
        {4'd6, 12'd101,  12'd200,  8'd14, 12'd100,  12'd200,  1'b1, 1'b0, 3'd3}, // R6 hidden
        {4'd7, 12'd101,  12'd200,  8'd15, 12'd100,  12'd200,  1'b0, 1'b1, 3'd3}, // R7 blank
        {4'd8, 12'd100,  12'd200,  8'd16, 12'd100,  12'd200,  1'b0, 1'b0, 3'd2}, // R8 depth
        {4'd3, 12'd4095, 12'd4095, 8'd17, 12'd4090, 12'd4090, 1'b0, 1'b0, 3'd3}, // R3 far edge
        {4'd3, 12'd10,   12'd4095, 8'd18, 12'd4090, 12'd4090, 1'b0, 1'b0, 3'd3}, // R3 no wrap
        {4'd5, 12'd3,    12'd0,    8'd19, 12'd0,    12'd0,    1'b0, 1'b0, 3'd3}, // R5 origin
        {4'd4, 12'd20,   12'd3,    8'd20, 12'd0,    12'd0,    1'b0, 1'b0, 3'd3}, // R4 mid word
        {4'd8, 12'd104,  12'd200,  8'd21, 12'd100,  12'd200,  1'b0, 1'b0, 3'd7}  // R8 depth
    };

    logic [23:0] exp_rgb [0:N-1];
    logic        exp_err [0:N-1];

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_x = '0; in_y = '0; in_index = '0;
        cfg_cursor_pos = '0; cfg_cursor_off = 1'b0; cfg_blank = 1'b0; cfg_depth = 3'd3;
        cur_color_a = 24'h112233; cur_color_b = 24'h445566; cur_color_c = 24'h778899;
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 out_valid", 32'(out_valid), 32'd0);
        check("R10 out_rgb", 32'(out_rgb), 32'd0);
        check("R10 out_xy", {8'd0, out_x, out_y}, 32'd0);
        check("R10 out_depth_err", 32'(out_depth_err), 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < N + 2; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                int k;
                k = i - 2;
                check("R1 out_valid", 32'(out_valid), 32'd1);
                check("R1 out_xy", {8'd0, out_x, out_y}, {8'd0, VEC[k][60:49], VEC[k][48:37]});
                check($sformatf("R%0d rgb vec%0d", VEC[k][64:61], k), 32'(out_rgb), 32'(exp_rgb[k]));
                check("R8 depth flag", 32'(out_depth_err), 32'(exp_err[k]));
            end
            if (i < N) begin
                in_valid       = 1'b1;
                in_x           = VEC[i][60:49];
                in_y           = VEC[i][48:37];
                in_index       = VEC[i][36:29];
                cfg_cursor_pos = VEC[i][28:5];
                cfg_cursor_off = VEC[i][4];
                cfg_blank      = VEC[i][3];
                cfg_depth      = VEC[i][2:0];
                exp_rgb[i] = model(int'(VEC[i][60:49]), int'(VEC[i][48:37]), VEC[i][36:29],
                                   int'(VEC[i][28:17]), int'(VEC[i][16:5]),
                                   VEC[i][4], VEC[i][3], VEC[i][2:0]);
                exp_err[i] = (VEC[i][2:0] != 3'd3);
            end else begin
                in_valid = 1'b0;
            end
        end

        // R4 and R2 address outputs in the same cycle as the pixel
        cfg_cursor_pos = {12'd100, 12'd200}; cfg_cursor_off = 1'b0;
        cfg_blank = 1'b0; cfg_depth = 3'd3;
        in_x = 12'd117; in_y = 12'd203; in_index = 8'hA7;
        #1;
        check("R4 pat_raddr mid", 32'(pat_raddr), 32'd26);
        check("R2 pal_raddr", 32'(pal_raddr), 32'hA7);
        in_x = 12'd163; in_y = 12'd263;
        #1;
        check("R4 pat_raddr corner", 32'(pat_raddr), 32'd511);

        // R9 idle output stays black
        repeat (3) @(negedge clk);
        check("R9 idle valid", 32'(out_valid), 32'd0);
        check("R9 idle rgb", 32'(out_rgb), 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule